// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block brings a DDR SDRAM device out of power-up by itself, with no processor involvement. After a start pulse it raises the clock-enable line and plays a fixed eight-step command list onto the address, bank and RAS/CAS/WE pins. Each command is held for exactly one clock cycle and is followed by a programmable run of idle cycles. The last command is followed by a longer idle period. When that period ends, the block raises a done flag so the main memory controller can take over the pins.

The order of the steps follows a DLL-off bring-up:
- a clock-enable NOP;
- a precharge of all banks;
- an extended-mode write that disables the DLL;
- a mode write with the DLL-reset bit set;
- a second precharge of all banks;
- two auto-refresh commands;
- a final mode write with the DLL-reset bit cleared.

The burst length, 2 or 4, is chosen by a parameter. It changes only the low field of the two mode writes.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset, and until a start pulse is seen, CKE is low, {ras_n,cas_n,we_n} = 3'b111 (NOP), the address and bank are zero, and done is low.
- R2: A start pulse seen in idle produces eight one-cycle commands in this order. Command codes are LMR=000, REF=001, PRE=010 and NOP=111. Steps 0 to 6 are: NOP (row 0, bank 0), PRE (row 0x400, bank 0), LMR (row 0x001, bank 1), LMR (bank 0), PRE (row 0x400, bank 0), REF (row 0, bank 0) and REF (row 0, bank 0). Step 7 is LMR on bank 0.
- R3: The step-3 mode value is 0x121 for burst length 2 and 0x122 for burst length 4. The step-7 mode value is 0x021 for burst length 2 and 0x022 for burst length 4.
- R4: Step k appears in the k*(GAP_CYC+1)-th cycle after the clock edge that samples start. Between two steps there are exactly GAP_CYC cycles.
- R5: After step 7, exactly FINAL_CYC idle cycles pass, and then done rises.
- R6: Once done is high it stays high until reset, and the pins stay NOP. Once CKE is high it stays high until reset.
- R7: The start input has no effect while a sequence runs or after done.
- R8: In every gap and idle cycle the pins drive NOP with address 0 and bank 0.
- R9: A reset in the middle of a sequence returns the pins to the R1 state. A later start runs the full sequence again from step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins the sequence when idle |
| sd_addr_o | output | ROW_W | SDRAM address lines |
| sd_ba_o | output | BANK_W | SDRAM bank address |
| sd_ras_no | output | 1 | Row address strobe, active low |
| sd_cas_no | output | 1 | Column address strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_cke_o | output | 1 | SDRAM clock enable |
| done_o | output | 1 | Initialization complete, sticky |

## Verification
The bench compares every pin on every cycle against a timeline computed from the gap parameters. A design with an off-by-one in the gap counter would therefore show steps a cycle early or late, and a missing tail cycle would raise done one cycle too soon. Two instances with burst lengths 2 and 4 run side by side, so a mode value that ignores the burst parameter or keeps the DLL-reset bit on the last write shows up at step 3 or step 7. Start pulses during the run and after done would restart a design that does not lock start out, and that restart would break the timeline. A reset applied mid-sequence, followed by a fresh start, catches a step index or a CKE flag that survives reset.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  localparam int NUM_STEPS = 8;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_CMD,
    SEQ_GAP,
    SEQ_TAIL,
    SEQ_DONE
  } seq_state_e;
endpackage

// File: rtl/ddr_init_rom.sv
module ddr_init_rom
  import ddr_init_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 2
) (
  input  logic [STEP_W-1:0] step_i,
  output sd_cmd_e           cmd_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [2:0] bl_code;

  generate
    if (BURST_LEN == 4) begin : g_bl4
      assign bl_code = 3'd2;
    end else begin : g_bl2
      assign bl_code = 3'd1;
    end
  endgenerate

  // mode word: DLL reset at bit 8, CAS latency 2 in bits 6:4, burst code in bits 2:0
  logic [ROW_W-1:0] mode_run, mode_rst;
  assign mode_run = ROW_W'(12'h020) | ROW_W'(bl_code);
  assign mode_rst = mode_run | ROW_W'(12'h100);

  localparam logic [ROW_W-1:0] ROW_PALL = ROW_W'(12'h400);
  localparam logic [ROW_W-1:0] ROW_EMR  = ROW_W'(12'h001);

  always_comb begin
    cmd_o  = CMD_NOP;
    row_o  = '0;
    bank_o = '0;
    unique case (step_i)
      3'd0: cmd_o = CMD_NOP;
      3'd1, 3'd4: begin
        cmd_o = CMD_PRE;
        row_o = ROW_PALL;
      end
      3'd2: begin
        cmd_o  = CMD_LMR;
        row_o  = ROW_EMR;
        bank_o = BANK_W'(1);
      end
      3'd3: begin
        cmd_o = CMD_LMR;
        row_o = mode_rst;
      end
      3'd5, 3'd6: cmd_o = CMD_REF;
      default: begin
        cmd_o = CMD_LMR;
        row_o = mode_run;
      end
    endcase
  end
endmodule

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
#(
  parameter int GAP_CYC   = 4,
  parameter int FINAL_CYC = 200,
  parameter int CNT_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tmr_zero_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic [STEP_W-1:0] step_o,
  output logic              issue_o,
  output logic              cke_o,
  output logic              done_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic              cke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      step_q  <= '0;
      cke_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_CMD;
          step_q  <= '0;
          cke_q   <= 1'b1;
        end
        SEQ_CMD:  state_q <= (step_q == LAST_STEP) ? SEQ_TAIL : SEQ_GAP;
        SEQ_GAP:  if (tmr_zero_i) begin
          state_q <= SEQ_CMD;
          step_q  <= step_q + 1'b1;
        end
        SEQ_TAIL: if (tmr_zero_i) state_q <= SEQ_DONE;
        default:  state_q <= SEQ_DONE;
      endcase
    end
  end

  assign tmr_load_o = (state_q == SEQ_CMD);
  assign tmr_val_o  = (step_q == LAST_STEP) ? CNT_W'(FINAL_CYC - 1) : CNT_W'(GAP_CYC - 1);
  assign step_o     = step_q;
  assign issue_o    = (state_q == SEQ_CMD);
  assign cke_o      = cke_q;
  assign done_o     = (state_q == SEQ_DONE);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 2,
  parameter int GAP_CYC   = 4,
  parameter int FINAL_CYC = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ROW_W-1:0]  sd_addr_o,
  output logic [BANK_W-1:0] sd_ba_o,
  output logic              sd_ras_no,
  output logic              sd_cas_no,
  output logic              sd_we_no,
  output logic              sd_cke_o,
  output logic              done_o
);
  localparam int MAX_CYC = (GAP_CYC > FINAL_CYC) ? GAP_CYC : FINAL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic              tmr_load, tmr_zero, issue;
  logic [CNT_W-1:0]  tmr_val;
  logic [STEP_W-1:0] step;
  sd_cmd_e           rom_cmd, pin_cmd;
  logic [ROW_W-1:0]  rom_row;
  logic [BANK_W-1:0] rom_bank;

  ddr_init_ctrl #(
    .GAP_CYC(GAP_CYC), .FINAL_CYC(FINAL_CYC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .step_o(step), .issue_o(issue), .cke_o(sd_cke_o), .done_o(done_o)
  );

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  ddr_init_rom #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .BURST_LEN(BURST_LEN)
  ) u_rom (
    .step_i(step), .cmd_o(rom_cmd), .row_o(rom_row), .bank_o(rom_bank)
  );

  assign pin_cmd   = issue ? rom_cmd : CMD_NOP;
  assign sd_addr_o = issue ? rom_row : '0;
  assign sd_ba_o   = issue ? rom_bank : '0;
  assign {sd_ras_no, sd_cas_no, sd_we_no} = pin_cmd;
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cmd_i,
  input logic       cke_i,
  input logic       done_i
);
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_i);                                       // R6
  AST_CKE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i |=> cke_i);                                         // R6
  AST_DONE_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (cmd_i == 3'b111));                            // R6
  AST_NO_CMD_WITHOUT_CKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |-> (cmd_i == 3'b111 && !done_i));                 // R1
  AST_GAP_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != 3'b111) |=> (cmd_i == 3'b111));                 // R4
  AST_DONE_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(cmd_i == 3'b111));                // R5
endmodule

bind ddr_init_seq ddr_init_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cmd_i({sd_ras_no, sd_cas_no, sd_we_no}),
  .cke_i(sd_cke_o), .done_i(done_o)
);

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 13;
  localparam int BANK_W = 2;
  localparam int GAP = 3;
  localparam int FIN = 12;
  localparam int P = GAP + 1;
  localparam int LAST_AT = 7 * P;
  localparam int RUN_LEN = LAST_AT + FIN + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [ROW_W-1:0] a2, a4;
  logic [BANK_W-1:0] b2, b4;
  logic r2, c2, w2, k2, d2, r4, c4, w4, k4, d4;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_init_seq #(.ROW_W(ROW_W), .BANK_W(BANK_W), .BURST_LEN(2), .GAP_CYC(GAP), .FINAL_CYC(FIN))
    u_ddr_init_seq (.clk_i(clk), .rst_ni(rst_n), .start_i(start), .sd_addr_o(a2), .sd_ba_o(b2),
      .sd_ras_no(r2), .sd_cas_no(c2), .sd_we_no(w2), .sd_cke_o(k2), .done_o(d2));

  ddr_init_seq #(.ROW_W(ROW_W), .BANK_W(BANK_W), .BURST_LEN(4), .GAP_CYC(GAP), .FINAL_CYC(FIN))
    u_ddr_init_seq_bl4 (.clk_i(clk), .rst_ni(rst_n), .start_i(start), .sd_addr_o(a4), .sd_ba_o(b4),
      .sd_ras_no(r4), .sd_cas_no(c4), .sd_we_no(w4), .sd_cke_o(k4), .done_o(d4));

  // packed view: {cke, done, cmd[2:0], bank, row}
  function automatic logic [ROW_W+BANK_W+4:0] expect_at(int n, bit bl4);
    logic [2:0] cmd = 3'b111;
    logic [BANK_W-1:0] ba = '0;
    logic [ROW_W-1:0] row = '0;
    logic done = (n > LAST_AT + FIN);
    if (n <= LAST_AT && (n % P) == 0) begin
      case (n / P)
        1, 4: begin cmd = 3'b010; row = 13'h400; end
        2:    begin cmd = 3'b000; row = 13'h001; ba = 2'd1; end
        3:    begin cmd = 3'b000; row = bl4 ? 13'h122 : 13'h121; end
        5, 6: cmd = 3'b001;
        7:    begin cmd = 3'b000; row = bl4 ? 13'h022 : 13'h021; end
        default: cmd = 3'b111;
      endcase
    end
    return {1'b1, done, cmd, ba, row};
  endfunction

  function automatic string tag_at(int n);
    if (n > LAST_AT + FIN) return "R6";
    if (n > LAST_AT) return "R5";
    if ((n % P) != 0) return "R4,R8";
    if (n / P == 3 || n / P == 7) return "R3";
    return "R2";
  endfunction

  task automatic check(string tag, logic [ROW_W+BANK_W+4:0] got, logic [ROW_W+BANK_W+4:0] exp, int n);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, n, got, exp);
    end
  endtask

  task automatic check_idle(string tag);
    check(tag, {k2, d2, r2, c2, w2, b2, a2}, {2'b00, 3'b111, {BANK_W{1'b0}}, {ROW_W{1'b0}}}, -1);
    check(tag, {k4, d4, r4, c4, w4, b4, a4}, {2'b00, 3'b111, {BANK_W{1'b0}}, {ROW_W{1'b0}}}, -1);
  endtask

  // launch start and compare every cycle up to `upto`; extra start pulses at given cycles
  task automatic run_seq(int upto, int pulse_a, int pulse_b);
    @(negedge clk) start = 1'b1;
    for (int n = 0; n <= upto; n++) begin
      @(negedge clk);
      check(tag_at(n), {k2, d2, r2, c2, w2, b2, a2}, expect_at(n, 1'b0), n);
      check(tag_at(n), {k4, d4, r4, c4, w4, b4, a4}, expect_at(n, 1'b1), n);
      start = (n == pulse_a || n == pulse_b);
    end
    start = 1'b0;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");
  endtask

  task automatic test_full_run();
    // R7: start re-pulsed during steps and the tail
    run_seq(RUN_LEN, 5, LAST_AT + 2);
  endtask

  task automatic test_start_after_done();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) start = (i % 2 == 0);
      check("R7", {k2, d2, r2, c2, w2, b2, a2}, expect_at(RUN_LEN + 1, 1'b0), i);
      check("R7", {k4, d4, r4, c4, w4, b4, a4}, expect_at(RUN_LEN + 1, 1'b1), i);
    end
    start = 1'b0;
  endtask

  task automatic test_mid_reset();
    rst_n = 1'b0;
    #1 check_idle("R9");
    @(negedge clk) rst_n = 1'b1;
    run_seq(2 * P + 1, -1, -1);
    @(negedge clk) rst_n = 1'b0;
    #1 check_idle("R9");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R9");
    run_seq(RUN_LEN, -1, -1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    test_reset();
    test_full_run();
    test_start_after_done();
    test_mid_reset();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule